// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the eight-bit status and control word of a serial memory and works out, every cycle, whether a write may proceed. The serial front end decodes commands and hands them in as one-cycle strobes: latch set, latch clear, status-word load with its data byte, internal-write finished, and access finished. The block also watches the hardware protect pin, the busy flag of the write engine, and the byte address under way. In return it presents the word for status reads, a permit for a data-byte write, and a permit for a status-word load.

Some fields stand for nonvolatile cells. These are the protect enable, the page lock and the two block-protect bits. Their flops take a start value from parameters and ignore the soft reset. The page-select bit, the write-enable latch and the busy copy are volatile and clear on reset. While page select is 1, a data-byte permit refers to the small identification page. While it is 0, the permit refers to the main array. All pins are plain level or strobe signals, and none of them carries a stream or a handshake.

Top module: `status_guard`

## Requirements
- R1: `status_o` is laid out as bit 7 protect enable, bit 6 page select, bit 5 constant 0, bit 4 page lock, bits 3:2 block-protect code, bit 1 write-enable latch, bit 0 busy.
- R2: The write-enable latch sets one cycle after `set_wel_i`. It clears one cycle after `clr_wel_i` or `write_done_i`, and a clear wins over a set in the same cycle. A status load never changes bits 1 and 0.
- R3: `sr_wr_ok_o` is 1 exactly when the latch is 1 and either the protect enable is 0 or `wp_pin_i` is 1.
- R4: A `wrsr_i` strobe with `sr_wr_ok_o` high loads bits 7 and 3:2 from `wrsr_data_i` on the next edge. A strobe with `sr_wr_ok_o` low changes nothing.
- R5: A permitted load whose data has both bit 6 and bit 4 at 1 leaves page select and page lock at their old values. Otherwise it writes data bit 6 to page select.
- R6: Page lock, once 1, stays 1 through every later load and reset. A permitted load with data bit 4 set makes it 1.
- R7: Page select clears one cycle after `access_done_i`. This wins over a load in the same cycle.
- R8: With page select 0, `arr_wr_ok_o` is the latch ANDed with "address not guarded". Block code 00 guards nothing, 01 guards addresses whose top two bits are 11, 10 guards addresses whose top bit is 1, and 11 guards every address.
- R9: With page select 1, `arr_wr_ok_o` is the latch ANDed with NOT page lock, whatever the block code is.
- R10: A low `rst_n` at an edge clears bits 6, 1 and 0 and keeps bits 7, 4, 3 and 2. After power-up those kept bits start at the parameter values (0 by default).
- R11: Bit 0 equals the `busy_i` value seen at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low soft reset |
| set_wel_i | input | 1 | Strobe: set write-enable latch |
| clr_wel_i | input | 1 | Strobe: clear write-enable latch |
| wrsr_i | input | 1 | Strobe: load status word |
| wrsr_data_i | input | 8 | Data byte for status load |
| write_done_i | input | 1 | Strobe: internal write cycle finished |
| access_done_i | input | 1 | Strobe: read or write access finished |
| wp_pin_i | input | 1 | Hardware protect pin, 1 = writes allowed |
| busy_i | input | 1 | Write engine busy |
| addr_i | input | ADDR_W (14) | Target byte address |
| status_o | output | 8 | Status word |
| arr_wr_ok_o | output | 1 | Data-byte write permitted |
| sr_wr_ok_o | output | 1 | Status-word load permitted |

## Verification
The status word is fully registered, so a strobe or pin change shows in `status_o` after exactly one rising edge. Both permits are combinational and follow the current state and the current pins in the same cycle. The bench drives inputs on the falling edge and samples the outputs 1 ns later. It compares the permits against a model built from the present inputs and the model state. It compares `status_o` against the model state, and that state is advanced only at the rising edge that consumes the inputs, so each result is checked in the cycle it becomes due.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int SB_BUSY  = 0;
  localparam int SB_WEL   = 1;
  localparam int SB_BPLO  = 2;
  localparam int SB_BPHI  = 3;
  localparam int SB_LOCK  = 4;
  localparam int SB_ZERO  = 5;
  localparam int SB_IDSEL = 6;
  localparam int SB_HWEN  = 7;

  typedef enum logic [1:0] {
    GUARD_NONE    = 2'b00,
    GUARD_QUARTER = 2'b01,
    GUARD_HALF    = 2'b10,
    GUARD_ALL     = 2'b11
  } guard_e;

  // top2 = two most significant address bits
  function automatic logic addr_guarded(input guard_e code, input logic [1:0] top2);
    case (code)
      GUARD_NONE:    return 1'b0;
      GUARD_QUARTER: return top2 == 2'b11;
      GUARD_HALF:    return top2[1];
      default:       return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sgp_volatile.sv
module sgp_volatile (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wel,
  input  logic clr_wel,
  input  logic write_done,
  input  logic busy,
  input  logic access_done,
  input  logic idsel_load,
  input  logic idsel_d,
  output logic wel_q,
  output logic idsel_q,
  output logic busy_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      idsel_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      if (clr_wel || write_done) wel_q <= 1'b0;
      else if (set_wel)          wel_q <= 1'b1;
      if (access_done)           idsel_q <= 1'b0;
      else if (idsel_load)       idsel_q <= idsel_d;
    end
  end

  p_wel_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wel || write_done) |=> !wel_q);
  p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wel && !clr_wel && !write_done) |=> wel_q);
  p_idsel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    access_done |=> !idsel_q);
  p_busy_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (busy_q == $past(busy)));
endmodule

// File: rtl/sgp_nonvol.sv
module sgp_nonvol #(
  parameter logic       INIT_HWEN = 1'b0,
  parameter logic       INIT_LOCK = 1'b0,
  parameter logic [1:0] INIT_BP   = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic       hwen_q,
  output logic       lock_q,
  output logic [1:0] bp_q,
  output logic       idsel_load,
  output logic       idsel_d
);
  import sgp_pkg::*;

  logic both_set;
  logic hwen_r = INIT_HWEN;
  logic lock_r = INIT_LOCK;
  logic [1:0] bp_r = INIT_BP;

  assign both_set = data[SB_IDSEL] & data[SB_LOCK];

  // no reset term: these flops model cells that survive a soft reset
  always_ff @(posedge clk) begin
    if (load) begin
      hwen_r <= data[SB_HWEN];
      bp_r   <= data[SB_BPHI:SB_BPLO];
      if (!both_set) lock_r <= lock_r | data[SB_LOCK];
    end
  end

  assign hwen_q     = hwen_r;
  assign lock_q     = lock_r;
  assign bp_q       = bp_r;
  assign idsel_load = load & ~both_set;
  assign idsel_d    = data[SB_IDSEL];

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_r |=> lock_r);
  p_pair_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && both_set) |=> $stable(lock_r));
endmodule

// File: rtl/sgp_guard.sv
module sgp_guard #(
  parameter int ADDR_W = 14
) (
  input  logic              hwen,
  input  logic              wp_pin,
  input  logic              wel,
  input  logic              idsel,
  input  logic              lock,
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              arr_ok,
  output logic              sr_ok
);
  import sgp_pkg::*;

  localparam int TOP = ADDR_W - 1;

  logic guarded;
  assign guarded = addr_guarded(guard_e'(bp), addr[TOP -: 2]);
  assign sr_ok   = wel & (~hwen | wp_pin);
  assign arr_ok  = wel & (idsel ? ~lock : ~guarded);
endmodule

// File: rtl/status_guard.sv
module status_guard #(
  parameter int         ADDR_W    = 14,
  parameter logic       INIT_HWEN = 1'b0,
  parameter logic       INIT_LOCK = 1'b0,
  parameter logic [1:0] INIT_BP   = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              write_done_i,
  input  logic              access_done_i,
  input  logic              wp_pin_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o
);
  import sgp_pkg::*;

  logic wel, idsel, busy_q, hwen, lock, idsel_load, idsel_d, sr_ok, nv_load;
  logic [1:0] bp;

  assign nv_load = rst_n & wrsr_i & sr_ok;

  sgp_volatile u_vol (
    .clk(clk), .rst_n(rst_n), .set_wel(set_wel_i), .clr_wel(clr_wel_i),
    .write_done(write_done_i), .busy(busy_i), .access_done(access_done_i),
    .idsel_load(idsel_load), .idsel_d(idsel_d),
    .wel_q(wel), .idsel_q(idsel), .busy_q(busy_q)
  );

  sgp_nonvol #(.INIT_HWEN(INIT_HWEN), .INIT_LOCK(INIT_LOCK), .INIT_BP(INIT_BP)) u_nv (
    .clk(clk), .rst_n(rst_n), .load(nv_load), .data(wrsr_data_i),
    .hwen_q(hwen), .lock_q(lock), .bp_q(bp),
    .idsel_load(idsel_load), .idsel_d(idsel_d)
  );

  sgp_guard #(.ADDR_W(ADDR_W)) u_guard (
    .hwen(hwen), .wp_pin(wp_pin_i), .wel(wel), .idsel(idsel), .lock(lock),
    .bp(bp), .addr(addr_i), .arr_ok(arr_wr_ok_o), .sr_ok(sr_ok)
  );

  assign sr_wr_ok_o = sr_ok;

  always_comb begin
    status_o                  = '0;
    status_o[SB_HWEN]         = hwen;
    status_o[SB_IDSEL]        = idsel;
    status_o[SB_LOCK]         = lock;
    status_o[SB_BPHI:SB_BPLO] = bp;
    status_o[SB_WEL]          = wel;
    status_o[SB_BUSY]         = busy_q;
  end

  p_full_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[SB_BPHI:SB_BPLO] == 2'b11 && !status_o[SB_IDSEL]) |-> !arr_wr_ok_o);
  p_locked_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[SB_IDSEL] && status_o[SB_LOCK]) |-> !arr_wr_ok_o);
  p_refused_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !sr_wr_ok_o) |=> $stable(status_o[7:2]) || $past(access_done_i));
  p_hw_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[SB_HWEN] && !wp_pin_i) |-> !sr_wr_ok_o);
endmodule

// File: tb/tb_status_guard.sv
module tb_status_guard;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_wel_i = 0, clr_wel_i = 0, wrsr_i = 0, write_done_i = 0;
  logic access_done_i = 0, wp_pin_i = 1, busy_i = 0;
  logic [7:0] wrsr_data_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] status_o;
  logic arr_wr_ok_o, sr_wr_ok_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic m_hwen = 0, m_idsel = 0, m_lock = 0, m_wel = 0, m_busy = 0;
  logic [1:0] m_bp = 2'b00;

  status_guard #(.ADDR_W(AW)) dut (.*);

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_status();
    return {m_hwen, m_idsel, 1'b0, m_lock, m_bp, m_wel, m_busy};
  endfunction

  function automatic logic exp_guarded(input logic [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a[AW-1] & a[AW-2];
      2'b10: return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic exp_sr();
    return m_wel & (~m_hwen | wp_pin_i);
  endfunction

  function automatic logic exp_arr();
    return m_idsel ? (m_wel & ~m_lock) : (m_wel & ~exp_guarded(m_bp, addr_i));
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic ok;
    ok = exp_sr();
    if (!rst_n) begin
      m_idsel = 0; m_wel = 0; m_busy = 0;
    end else begin
      m_busy = busy_i;
      if (wrsr_i && ok) begin
        m_hwen = wrsr_data_i[7];
        m_bp   = wrsr_data_i[3:2];
        if (!(wrsr_data_i[6] && wrsr_data_i[4])) begin
          m_lock  = m_lock | wrsr_data_i[4];
          m_idsel = wrsr_data_i[6];
        end
      end
      if (access_done_i) m_idsel = 0;
      if (clr_wel_i || write_done_i) m_wel = 0;
      else if (set_wel_i) m_wel = 1;
    end
  endtask

  // inputs are already driven (after a falling edge); check, then run one edge
  task automatic step();
    #1;
    chk(status_o, exp_status(), "R1 R2 R4 R5 R6 R7 R10 R11 status");
    chk({7'd0, sr_wr_ok_o}, {7'd0, exp_sr()}, "R3 status permit");
    chk({7'd0, arr_wr_ok_o}, {7'd0, exp_arr()},
        m_idsel ? "R9 page permit" : "R8 array permit");
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    set_wel_i = 0; clr_wel_i = 0; wrsr_i = 0; write_done_i = 0; access_done_i = 0;
  endtask

  task automatic load_sr(input logic [7:0] d);
    idle(); wrsr_i = 1; wrsr_data_i = d; step(); idle();
  endtask

  task automatic enable();
    idle(); set_wel_i = 1; step(); idle();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5A17);
    @(negedge clk);
    step(); step();
    rst_n = 1;
    // R10 power-up values
    #1 chk(status_o, 8'h00, "R10 reset state");
    @(negedge clk);
    // R2 set then a status load cannot touch bits 1,0
    enable();
    load_sr(8'h00);
    chk(status_o[1:0], 2'b10, "R2 load leaves latch");
    // R8 quarter guard
    enable(); load_sr(8'b0000_0100);
    enable(); addr_i = 14'h3000; step();
    addr_i = 14'h2FFF; step();
    // R8 half and full
    load_sr(8'b0000_1000); enable(); addr_i = 14'h2000; step();
    load_sr(8'b0000_1100); enable(); addr_i = 14'h0000; step();
    // R3 hardware protect blocks loads
    load_sr(8'b1000_0000); enable(); wp_pin_i = 0; step();
    load_sr(8'b0000_0000);
    chk(status_o[7], 1'b1, "R4 refused load kept bit 7");
    wp_pin_i = 1; enable(); load_sr(8'h00);
    // R5 both bits together: kept
    enable(); load_sr(8'b0101_0000);
    chk({status_o[6], status_o[4]}, 2'b00, "R5 pair rejected");
    // R9 page select, unlocked
    enable(); load_sr(8'b0100_1100); enable(); addr_i = 14'h3FFF; step();
    chk(arr_wr_ok_o, 1'b1, "R9 page writable");
    // R7 access done clears page select, wins over load
    access_done_i = 1; wrsr_i = 1; wrsr_data_i = 8'h40; step(); idle();
    chk(status_o[6], 1'b0, "R7 select cleared");
    // R6 lock and stickiness
    enable(); load_sr(8'b0001_0000); enable(); load_sr(8'b0000_0000);
    chk(status_o[4], 1'b1, "R6 lock sticky");
    enable(); load_sr(8'b0100_0000); enable(); step();
    chk(arr_wr_ok_o, 1'b0, "R9 locked page refused");
    // R10 soft reset keeps nonvolatile bits
    enable(); load_sr(8'b1000_1000); enable(); busy_i = 1; step();
    rst_n = 0; step(); rst_n = 1; busy_i = 0;
    #1 chk(status_o, 8'b1001_1000, "R10 soft reset keeps 7,4,3:2");
    @(negedge clk);
    // R11 busy copy
    busy_i = 1; step(); busy_i = 0;
    chk(status_o[0], 1'b1, "R11 busy copy");
    // R2 clear wins over set
    set_wel_i = 1; clr_wel_i = 1; step(); idle();
    chk(status_o[1], 1'b0, "R2 clear wins");
    enable(); write_done_i = 1; step(); idle();
    chk(status_o[1], 1'b0, "R2 write done clears latch");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      set_wel_i     = ($urandom % 3) == 0;
      clr_wel_i     = ($urandom % 8) == 0;
      write_done_i  = ($urandom % 10) == 0;
      wrsr_i        = ($urandom % 4) == 0;
      access_done_i = ($urandom % 10) == 0;
      wp_pin_i      = $urandom % 2;
      busy_i        = $urandom % 2;
      addr_i        = AW'($urandom);
      wrsr_data_i   = 8'($urandom) & (($urandom % 16) == 0 ? 8'hFF : 8'hEF);
      rst_n         = ($urandom % 100) != 0;
      step();
    end
    rst_n = 1; idle();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule